// File: doc/BRIEF.md
# Byte-Serial Multicycle Processor Controller

This block is the sequencing brain of a small multicycle processor whose datapath is eight bits wide while its instructions are 32 bits wide. It steps through a fixed sequence of states per instruction. It drives the memory strobes, the instruction-register byte enables, the program-counter update controls and the multiplexer and ALU-mode selects of the datapath. The only inputs it sees are the 6-bit opcode already held in the instruction register and the ALU zero flag.

Every instruction starts with four byte fetches. Each fetch loads one byte of the instruction register and advances the program counter. A decode cycle follows, and the controller then branches into a short per-class tail: a byte load, a byte store, a register-to-register ALU operation, a conditional branch on equality, or an unconditional jump. Each tail ends by going back to the first fetch. All outputs are a pure function of the current state, except the combined program-counter enable, which also folds in the zero flag.

Top module: `mc8_ctrl`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any clock edge with `rst` high, the controller is in the first fetch state (only bit 0 of `ir_byte_we` set).
- R2: Four fetch states run back to back. In fetch k (k = 0..3), `ir_byte_we` has only bit k set. `mem_rd` and `pc_wr` are 1, `alu_b_sel` is 01, and `pc_next_sel` and `alu_mode` are 00. Every other select and strobe is 0.
- R3: The decode state follows fetch 3 and drives `alu_b_sel` = 11 with every other output 0. It dispatches on `opcode`: 000000 register-type, 100000 byte load, 101000 byte store, 000100 branch-if-equal, 000010 jump.
- R4: In decode, any opcode outside those five leads to the first fetch state on the next cycle.
- R5: Byte load and byte store go from decode to an address state with `alu_a_sel` = 1 and `alu_b_sel` = 10. From there, load goes to the load-read state, store goes to the store state, and any other opcode goes to the first fetch state.
- R6: The load-read state drives `mem_rd` = 1 and `addr_sel_data` = 1. It is followed by a load write-back state with `rf_we` = 1, `wb_from_mem` = 1 and `dst_sel_rd` = 0.
- R7: The store state drives `mem_wr` = 1 and `addr_sel_data` = 1.
- R8: Register-type goes to an execute state (`alu_a_sel` = 1, `alu_b_sel` = 00, `alu_mode` = 10). It then goes to a completion state with `rf_we` = 1, `dst_sel_rd` = 1 and `wb_from_mem` = 0.
- R9: The branch state drives `pc_wr_if_zero` = 1, `alu_a_sel` = 1, `alu_b_sel` = 00, `alu_mode` = 01 and `pc_next_sel` = 01.
- R10: The jump state drives `pc_wr` = 1 and `pc_next_sel` = 10.
- R11: `pc_en` equals `pc_wr | (pc_wr_if_zero & zero)` in every cycle.
- R12: The load write-back, store, register completion, branch and jump states all lead to the first fetch state. Any output not named for a state is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_byte_we | output | 4 | One-hot instruction-register byte write enable |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_if_zero | output | 1 | Program-counter write qualified by zero |
| pc_en | output | 1 | Combined program-counter enable |
| addr_sel_data | output | 1 | Memory address from ALU result register (1) or PC (0) |
| alu_a_sel | output | 1 | ALU A operand: register (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B operand select |
| alu_mode | output | 2 | ALU operation class |
| dst_sel_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| wb_from_mem | output | 1 | Write-back data from memory (1) or ALU (0) |
| rf_we | output | 1 | Register file write enable |
| pc_next_sel | output | 2 | Next-PC source select |

## Verification
Directed instruction streams cover each of the five classes in turn. They include a branch with zero high and with zero low, an unknown opcode in decode, and an opcode that changes to an unknown value while in the address state. Together these tell apart every dispatch arc and both values of the branch enable. A long run then feeds randomly chosen opcodes, valid ones weighted against arbitrary ones, with a random zero flag. Every cycle's full output vector is compared against a bench state model, so a wrong arc, a wrong select value or a stray strobe in any state shows up. A reset pulse inserted mid-instruction confirms the return to the first fetch from a non-fetch state.

// File: rtl/mc8_ctrl.sv
module mc8_ctrl #(
  parameter logic [5:0] OP_RTYPE = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100000,
  parameter logic [5:0] OP_STORE = 6'b101000,
  parameter logic [5:0] OP_BRZ   = 6'b000100,
  parameter logic [5:0] OP_JUMP  = 6'b000010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       zero,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [3:0] ir_byte_we,
  output logic       pc_wr,
  output logic       pc_wr_if_zero,
  output logic       pc_en,
  output logic       addr_sel_data,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_mode,
  output logic       dst_sel_rd,
  output logic       wb_from_mem,
  output logic       rf_we,
  output logic [1:0] pc_next_sel
);

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_DEC, S_ADR, S_LRD, S_LWB,
    S_SWR, S_EXE, S_RWB, S_BRN, S_JMP
  } st_t;

  st_t st, st_nx;

  always_ff @(posedge clk)
    if (rst) st <= S_F0;
    else     st <= st_nx;

  always_comb begin
    st_nx = S_F0;
    case (st)
      S_F0: st_nx = S_F1;
      S_F1: st_nx = S_F2;
      S_F2: st_nx = S_F3;
      S_F3: st_nx = S_DEC;
      S_DEC: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) st_nx = S_ADR;
        else if (opcode == OP_RTYPE)                 st_nx = S_EXE;
        else if (opcode == OP_BRZ)                   st_nx = S_BRN;
        else if (opcode == OP_JUMP)                  st_nx = S_JMP;
      end
      S_ADR: begin
        if (opcode == OP_LOAD)       st_nx = S_LRD;
        else if (opcode == OP_STORE) st_nx = S_SWR;
      end
      S_LRD: st_nx = S_LWB;
      S_EXE: st_nx = S_RWB;
      default: st_nx = S_F0;
    endcase
  end

  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; ir_byte_we = 4'b0000;
    pc_wr = 1'b0; pc_wr_if_zero = 1'b0; addr_sel_data = 1'b0;
    alu_a_sel = 1'b0; alu_b_sel = 2'b00; alu_mode = 2'b00;
    dst_sel_rd = 1'b0; wb_from_mem = 1'b0; rf_we = 1'b0;
    pc_next_sel = 2'b00;
    case (st)
      S_F0, S_F1, S_F2, S_F3: begin
        mem_rd     = 1'b1;
        pc_wr      = 1'b1;
        alu_b_sel  = 2'b01;
        ir_byte_we = 4'b0001 << st[1:0];
      end
      S_DEC: alu_b_sel = 2'b11;
      S_ADR: begin alu_a_sel = 1'b1; alu_b_sel = 2'b10; end
      S_LRD: begin mem_rd = 1'b1; addr_sel_data = 1'b1; end
      S_LWB: begin rf_we = 1'b1; wb_from_mem = 1'b1; end
      S_SWR: begin mem_wr = 1'b1; addr_sel_data = 1'b1; end
      S_EXE: begin alu_a_sel = 1'b1; alu_mode = 2'b10; end
      S_RWB: begin rf_we = 1'b1; dst_sel_rd = 1'b1; end
      S_BRN: begin
        pc_wr_if_zero = 1'b1; alu_a_sel = 1'b1;
        alu_mode = 2'b01; pc_next_sel = 2'b01;
      end
      S_JMP: begin pc_wr = 1'b1; pc_next_sel = 2'b10; end
      default: ;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_if_zero & zero);

endmodule

// File: rtl/mc8_ctrl_chk.sv
module mc8_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       zero,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [3:0] ir_byte_we,
  input logic       pc_wr,
  input logic       pc_wr_if_zero,
  input logic       pc_en,
  input logic       addr_sel_data,
  input logic       rf_we,
  input logic       wb_from_mem,
  input logic [1:0] alu_b_sel,
  input logic [1:0] pc_next_sel
);

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> (ir_byte_we == 4'b0001));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    ir_byte_we[0] |=> (ir_byte_we == 4'b0010));

  // R3
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    ir_byte_we[3] |=> (alu_b_sel == 2'b11 && ir_byte_we == 4'b0000));

  // R6
  load_wb_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel_data) |=> (rf_we && wb_from_mem));

  // R7
  store_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (addr_sel_data && !mem_rd));

  // R11
  branch_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_if_zero && !zero && !pc_wr) |-> !pc_en);

  // R12
  return_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we || mem_wr || pc_next_sel != 2'b00) |=> (ir_byte_we == 4'b0001));

endmodule

bind mc8_ctrl mc8_ctrl_chk u_chk (.*);

// File: tb/tb_mc8_ctrl.sv
`timescale 1ns/1ps
module tb_mc8_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic zero = 1'b0;
  logic mem_rd, mem_wr, pc_wr, pc_wr_if_zero, pc_en, addr_sel_data, alu_a_sel;
  logic dst_sel_rd, wb_from_mem, rf_we;
  logic [3:0] ir_byte_we;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  localparam logic [5:0] OPR = 6'b000000, OPL = 6'b100000, OPS = 6'b101000,
                         OPB = 6'b000100, OPJ = 6'b000010;

  always #10 clk = ~clk;

  mc8_ctrl dut (.*);

  function automatic logic [18:0] exp_vec(input int s);
    logic r, w, pw, pz, ad, a, dr, wm, we;
    logic [3:0] ir;
    logic [1:0] b, m, ns;
    {r, w, pw, pz, ad, a, dr, wm, we} = '0;
    ir = 4'b0; b = 2'b0; m = 2'b0; ns = 2'b0;
    case (s)
      0, 1, 2, 3: begin r = 1; pw = 1; b = 2'b01; ir = 4'b0001 << s; end
      4: b = 2'b11;
      5: begin a = 1; b = 2'b10; end
      6: begin r = 1; ad = 1; end
      7: begin we = 1; wm = 1; end
      8: begin w = 1; ad = 1; end
      9: begin a = 1; m = 2'b10; end
      10: begin we = 1; dr = 1; end
      11: begin pz = 1; a = 1; m = 2'b01; ns = 2'b01; end
      12: begin pw = 1; ns = 2'b10; end
      default: ;
    endcase
    return {r, w, ir, pw, pz, ad, a, b, m, dr, wm, we, ns};
  endfunction

  function automatic int next_st(input int s, input logic [5:0] op);
    case (s)
      0, 1, 2: return s + 1;
      3: return 4;
      4: begin
        if (op == OPL || op == OPS) return 5;
        if (op == OPR) return 9;
        if (op == OPB) return 11;
        if (op == OPJ) return 12;
        return 0;
      end
      5: return (op == OPL) ? 6 : (op == OPS) ? 8 : 0;
      6: return 7;
      9: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      0, 1, 2, 3: return "R2";
      4: return "R3";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9, 10: return "R8";
      11: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [18:0] dut_vec();
    return {mem_rd, mem_wr, ir_byte_we, pc_wr, pc_wr_if_zero, addr_sel_data,
            alu_a_sel, alu_b_sel, alu_mode, dst_sel_rd, wb_from_mem, rf_we, pc_next_sel};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input int s, input string tag);
    logic pe;
    check(tag, dut_vec(), exp_vec(s));
    pe = (s <= 3 || s == 12) || (s == 11 && zero);
    tests++;
    if (pc_en !== pe) begin
      fails++;
      $display("FAIL R11: pc_en got %b expected %b at %0t", pc_en, pe, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [5:0] dir_op [0:9];
  logic       dir_z  [0:9];

  initial begin
    int s;
    int prev;
    int instr;
    int pick;
    logic [5:0] prev_op;
    string tag;
    void'($urandom(32'd1234));
    dir_op[0] = OPL; dir_z[0] = 0;
    dir_op[1] = OPS; dir_z[1] = 1;
    dir_op[2] = OPR; dir_z[2] = 0;
    dir_op[3] = OPB; dir_z[3] = 1;
    dir_op[4] = OPB; dir_z[4] = 0;
    dir_op[5] = OPJ; dir_z[5] = 0;
    dir_op[6] = 6'h3f; dir_z[6] = 1;
    dir_op[7] = 6'b000001; dir_z[7] = 0;
    dir_op[8] = OPL; dir_z[8] = 1;
    dir_op[9] = OPL; dir_z[9] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state after reset
    check_all(0, "R1");
    rst = 1'b0;
    s = 0; prev = -1; instr = 0; prev_op = 6'd0;

    for (int i = 0; i < 4000; i++) begin
      if (s == 0) begin
        if (instr < 10) begin
          opcode = dir_op[instr]; zero = dir_z[instr];
        end else begin
          pick = $urandom % 8;
          case (pick)
            0: opcode = OPR; 1: opcode = OPL; 2: opcode = OPS;
            3: opcode = OPB; 4: opcode = OPJ;
            default: opcode = 6'($urandom);
          endcase
          zero = 1'($urandom);
        end
        instr++;
      end
      // directed: opcode turns unknown while in the address state (R5)
      if (s == 5 && instr == 10) opcode = 6'h15;
      if (s == 5 && instr > 10 && ($urandom % 16) == 0) opcode = 6'($urandom);
      if (instr > 10) zero = 1'($urandom);
      #1;
      if (prev == 4 && s == 0) tag = "R4";
      else if (prev >= 7 && prev != 9 && s == 0) tag = "R12";
      else tag = tag_of(s);
      check_all(s, tag);
      prev = s;
      prev_op = opcode;
      if (i == 2500 && s != 0) begin
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        s = 0; prev = -1;
        #1;
        // R1: mid-instruction reset
        check_all(0, "R1");
        @(posedge clk);
        @(negedge clk);
        s = 1;
        continue;
      end
      s = next_st(s, prev_op);
      @(posedge clk);
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule